// File: doc/BRIEF.md
# Buck PWM Gate Timing Controller

This block turns a per-period duty command into the two gate commands of a synchronous step-down converter. It runs from a fast system clock, and every time quantity is a count of clock ticks. A free-running period counter sets the switching frequency. In sync mode, a falling edge on an external sync input can restart the period early. The duty command is captured once at the start of each period. Before that period is switched, the command is checked against minimum on and off times. A command that is too short drops the high-side pulse for that period. A command that is too long keeps the high side on across the whole period.

Around this timing core sit the protection paths. An overcurrent flag ends the high-side pulse for the rest of the period, but only after a blanking window at the start of each high-side on-interval has passed. An output overvoltage flag or a bootstrap undervoltage flag holds the high side off. Because conduction is always continuous, the low side then carries the switch node: it is on whenever the high side is off, apart from the dead time. A shared dead-time counter inserts a programmable gap between the fall of one gate and the rise of the other.

The error amplifier, the comparators and the drivers stay outside. The flags arrive as clean, synchronous single-bit inputs, and the sync input is expected to be already synchronized to the clock.

Top module: `buck_gate_timer`

## Requirements
- R1: While rst_n is low, hs_gate and ls_gate are both low.
- R2: With sync_mode low, a period lasts exactly `period` clock ticks and sync_in has no effect on the gates.
- R3: For MIN_ON <= duty <= period - MIN_OFF, each period holds hs_gate high for duty - dead - 1 ticks and ls_gate high for period - duty - dead - 1 ticks. The design assumes dead + 2 <= MIN_ON and dead + 2 <= MIN_OFF.
- R4: If duty < MIN_ON, hs_gate stays low for the whole period and ls_gate stays high.
- R5: If duty + MIN_OFF > period (and duty >= MIN_ON), hs_gate stays high for the whole period and ls_gate stays low.
- R6: duty is sampled only at the start of a period. A change during the period does not alter that period's high-side pulse.
- R7: hs_gate and ls_gate are never high together. After either gate falls, both gates stay low for at least dead + 1 ticks before the other gate rises, where dead is the value in force at the fall.
- R8: If oc_flag is high in a cycle in which hs_gate has already been high for at least BLANK earlier cycles, hs_gate is low from the next cycle until the next period begins. ls_gate then rises after the dead gap. The following period switches normally.
- R9: oc_flag has no effect during the first BLANK cycles of a high-side on-interval.
- R10: While ov_flag is high, hs_gate is low from the next cycle on. ls_gate rises dead + 1 ticks after the high side falls and stays high.
- R11: While bts_uv is high, hs_gate is not driven high and ls_gate is held high.
- R12: With sync_mode high, a falling edge of sync_in starts a new period. Counting the first clock edge that samples sync_in low as edge 1, hs_gate rises at edge dead + 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | High: falling edges of sync_in restart the period |
| sync_in | input | 1 | External sync signal, already synchronized to clk |
| period | input | CW | Internal switching period in ticks |
| duty | input | CW | Commanded high-side window in ticks, captured at period start |
| dead | input | DTW | Dead time in ticks between gate transitions |
| oc_flag | input | 1 | Overcurrent comparator result |
| ov_flag | input | 1 | Output overvoltage comparator result |
| bts_uv | input | 1 | Bootstrap supply undervoltage flag |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |

## Verification
Most of the internal state shows up as gate widths within one period. A wrong period counter, a stale duty latch or a misread skip limit changes the number of high-side and low-side ticks in the very next period window. A stuck dead-time counter either closes the gap between the gates, which is an overlap, or stretches it, which takes ticks from both widths.

The overcurrent cut flag and the blanking counter only show themselves in the period where the flag is raised. A cut flag that fails to clear shows up one period later as a missing high-side pulse. Sync alignment errors appear as a shifted high-side rising edge a few ticks after the sync input falls.

// File: rtl/buck_gate_timer.sv
module buck_gate_timer #(
  parameter int unsigned CW      = 8,
  parameter int unsigned DTW     = 4,
  parameter int unsigned MIN_ON  = 20,
  parameter int unsigned MIN_OFF = 20,
  parameter int unsigned BLANK   = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sync_mode,
  input  logic           sync_in,
  input  logic [CW-1:0]  period,
  input  logic [CW-1:0]  duty,
  input  logic [DTW-1:0] dead,
  input  logic           oc_flag,
  input  logic           ov_flag,
  input  logic           bts_uv,
  output logic           hs_gate,
  output logic           ls_gate
);

  localparam int unsigned BW = $clog2(BLANK + 1);

  logic [CW-1:0]  cnt, on_q;
  logic           full_q, cut_q, sync_q;
  logic [DTW-1:0] dtc;
  logic [BW-1:0]  ton;

  wire            wrap      = ({1'b0, cnt} + 1'b1) >= {1'b0, period};
  wire            sync_fall = sync_mode & sync_q & ~sync_in;
  wire            start     = wrap | sync_fall;
  wire            short_on  = 32'(duty) < MIN_ON;
  wire            long_on   = 32'(duty) + MIN_OFF > 32'(period);
  wire            oc_now    = hs_gate & oc_flag & (ton == BW'(BLANK));
  wire            want_hs   = (full_q | (cnt < on_q)) & ~cut_q & ~oc_now & ~ov_flag & ~bts_uv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      on_q   <= '0;
      full_q <= 1'b0;
      cut_q  <= 1'b0;
      sync_q <= 1'b0;
      ton    <= '0;
    end else begin
      sync_q <= sync_in;
      cnt    <= start ? '0 : cnt + 1'b1;
      cut_q  <= start ? 1'b0 : (cut_q | oc_now);
      if (start) begin
        on_q   <= (short_on | long_on) ? '0 : duty;
        full_q <= long_on & ~short_on;
      end
      if (!hs_gate)
        ton <= '0;
      else if (ton != BW'(BLANK))
        ton <= ton + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_gate <= 1'b0;
      ls_gate <= 1'b0;
      dtc     <= '0;
    end else if (want_hs) begin
      if (ls_gate) begin
        ls_gate <= 1'b0;
        dtc     <= dead;
      end else if (!hs_gate) begin
        if (dtc == '0) hs_gate <= 1'b1;
        else           dtc     <= dtc - 1'b1;
      end
    end else begin
      if (hs_gate) begin
        hs_gate <= 1'b0;
        dtc     <= dead;
      end else if (!ls_gate) begin
        if (dtc == '0) ls_gate <= 1'b1;
        else           dtc     <= dtc - 1'b1;
      end
    end
  end

endmodule

// File: rtl/buck_gate_timer_checker.sv
module buck_gate_timer_checker #(
  parameter int unsigned DTW   = 4,
  parameter int unsigned BLANK = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [DTW-1:0] dead,
  input logic           oc_flag,
  input logic           ov_flag,
  input logic           bts_uv,
  input logic           hs_gate,
  input logic           ls_gate
);

  localparam int unsigned HW = $clog2(BLANK + 1);

  logic           hs_d, ls_d, armed;
  logic [5:0]     lowrun;
  logic [DTW-1:0] dead_d, dref;
  logic [HW-1:0]  hrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_d   <= 1'b0;
      ls_d   <= 1'b0;
      armed  <= 1'b0;
      lowrun <= '0;
      dead_d <= '0;
      dref   <= '0;
      hrun   <= '0;
    end else begin
      hs_d   <= hs_gate;
      ls_d   <= ls_gate;
      dead_d <= dead;
      if (hs_gate | ls_gate) armed <= 1'b1;
      if (hs_gate | ls_gate)  lowrun <= '0;
      else if (lowrun != 6'd63) lowrun <= lowrun + 1'b1;
      if ((hs_d & ~hs_gate) | (ls_d & ~ls_gate)) dref <= dead_d;
      if (!hs_gate) hrun <= '0;
      else if (hrun != HW'(BLANK)) hrun <= hrun + 1'b1;
    end
  end

  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  p_dead_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ((hs_gate && !hs_d) || (ls_gate && !ls_d))) |-> (lowrun > 6'(dref)));

  p_ov_hs_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ov_flag |=> !hs_gate);

  p_uv_hs_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bts_uv |=> !hs_gate);

  p_oc_cut_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_gate && oc_flag && hrun == HW'(BLANK)) |=> !hs_gate);

endmodule

bind buck_gate_timer buck_gate_timer_checker #(.DTW(DTW), .BLANK(BLANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .dead(dead), .oc_flag(oc_flag), .ov_flag(ov_flag),
  .bts_uv(bts_uv), .hs_gate(hs_gate), .ls_gate(ls_gate)
);

// File: tb/buck_gate_timer_tb.sv
`timescale 1ns/100ps
module buck_gate_timer_tb;
  localparam int CW = 8, DTW = 4, MINON = 20, MINOFF = 20, BLANK = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, sync_mode, sync_in, oc_flag, ov_flag, bts_uv, hs_gate, ls_gate;
  logic [CW-1:0]  period, duty;
  logic [DTW-1:0] dead;

  buck_gate_timer #(.CW(CW), .DTW(DTW), .MIN_ON(MINON), .MIN_OFF(MINOFF), .BLANK(BLANK)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .sync_in(sync_in), .period(period),
    .duty(duty), .dead(dead), .oc_flag(oc_flag), .ov_flag(ov_flag), .bts_uv(bts_uv),
    .hs_gate(hs_gate), .ls_gate(ls_gate));

  int checks = 0, errors = 0, cyc = 0, overlap = 0, sph = 0, last_fall = 0;
  bit sync_run = 0;

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (hs_gate && ls_gate) overlap++;
    if (sync_run) begin
      sph = (sph + 1) % 40;
      sync_in = (sph < 20);
      if (sph == 20) last_fall = cyc;
    end
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic measure(input int n, output int h, output int l);
    h = 0; l = 0;
    repeat (n) begin
      tick();
      if (hs_gate) h++;
      if (ls_gate) l++;
    end
  endtask

  function automatic void expect_counts(input int d, input int p, input int dt, output int eh, output int el);
    if (d < MINON) begin eh = 0; el = p; end
    else if (d + MINOFF > p) begin eh = p; el = 0; end
    else begin eh = d - dt - 1; el = p - d - dt - 1; end
  endfunction

  task automatic steady(input string req, input int d, input int p, input int dt, input int win);
    int h, l, eh, el;
    duty = CW'(d); period = CW'(p); dead = DTW'(dt);
    repeat (3 * 64 + 5) tick();
    measure(win, h, l);
    expect_counts(d, win, dt, eh, el);
    check(req, $sformatf("hs ticks d=%0d p=%0d dead=%0d", d, p, dt), h, eh);
    check(req, $sformatf("ls ticks d=%0d p=%0d dead=%0d", d, p, dt), l, el);
  endtask

  task automatic wait_rise();
    bit prev;
    int guard = 0;
    do begin
      prev = hs_gate;
      tick();
      guard++;
    end while (!(hs_gate && !prev) && guard < 1000);
  endtask

  initial begin
    #(150000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int h, l;
    rst_n = 0; sync_mode = 0; sync_in = 1; period = 60; duty = 30; dead = 3;
    oc_flag = 0; ov_flag = 0; bts_uv = 0;
    repeat (4) @(negedge clk);
    check("R1", "hs in reset", int'(hs_gate), 0);
    check("R1", "ls in reset", int'(ls_gate), 0);
    rst_n = 1;

    for (int d = 0; d <= 70; d++)
      steady(d < MINON ? "R4" : (d + MINOFF > 60 ? "R5" : "R3"), d, 60, 3, 60);

    for (int dt = 0; dt <= 15; dt++)
      steady("R7", 30, 60, dt, 60);

    for (int p = 40; p <= 64; p++)
      steady("R2", 20, p, 3, p);

    sync_run = 1;
    steady("R2", 30, 60, 3, 60);
    sync_run = 0; sync_in = 1;

    steady("R3", 30, 60, 3, 60);
    wait_rise();
    duty = 50;
    h = 1;
    while (hs_gate) begin tick(); if (hs_gate) h++; end
    check("R6", "hs width after mid-period duty change", h, 26);
    duty = 30;
    repeat (200) tick();

    wait_rise();
    oc_flag = 1; h = 1;
    for (int i = 1; i < 40; i++) begin
      tick();
      if (i == BLANK) oc_flag = 0;
      if (hs_gate) h++;
    end
    check("R9", "hs width with oc inside blanking", h, 26);

    wait_rise();
    h = 1; l = 0;
    for (int i = 1; i < 50; i++) begin
      tick();
      if (hs_gate) h++;
      if (ls_gate) l++;
      if (i == 10) oc_flag = 1;
      if (i == 11) oc_flag = 0;
    end
    check("R8", "hs width after oc cut", h, 11);
    check("R8", "ls ticks after oc cut", l, 35);
    wait_rise();
    h = 1;
    while (hs_gate) begin tick(); if (hs_gate) h++; end
    check("R8", "hs width next period", h, 26);

    wait_rise();
    ov_flag = 1;
    tick();
    check("R10", "hs one tick after ov", int'(hs_gate), 0);
    repeat (3) tick();
    check("R10", "ls still low inside dead gap", int'(ls_gate), 0);
    tick();
    check("R10", "ls high after dead gap", int'(ls_gate), 1);
    repeat (100) tick();
    measure(120, h, l);
    check("R10", "hs ticks under ov", h, 0);
    check("R10", "ls ticks under ov", l, 120);
    ov_flag = 0;
    steady("R10", 30, 60, 3, 60);

    bts_uv = 1;
    repeat (100) tick();
    measure(120, h, l);
    check("R11", "hs ticks under bts_uv", h, 0);
    check("R11", "ls ticks under bts_uv", l, 120);
    bts_uv = 0;
    steady("R11", 30, 60, 3, 60);

    sync_mode = 1; sph = 0; sync_in = 1; sync_run = 1;
    steady("R12", 20, 50, 3, 40);
    wait_rise();
    check("R12", "hs rise delay after sync fall", cyc - last_fall, 3 + 3);
    sync_run = 0; sync_mode = 0; sync_in = 1;

    check("R7", "overlap ticks", overlap, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule